// File: doc/BRIEF.md
# Display RAM Byte Distributor

This block sits between a byte-oriented command/data decoder and a display memory made of 4-bit words, one word per segment column. Each incoming data byte is split across a run of consecutive words. The number of words and the rows filled in each word depend on the selected drive multiplex mode. The block issues one masked word write per clock until the whole byte has been placed. It keeps a loadable write pointer and a 3-bit cascade subaddress counter. Writes reach the memory only when that counter equals the device's strapped 3-bit address, so several devices can share one data stream. The pointer steps whether or not a write was allowed.

The pointer covers addresses 0 to DEPTH-1. When a step passes the last address, the pointer returns to 0, the subaddress counter moves on to the next device, and a one-cycle overflow pulse is raised. A pointer load abandons any byte still being distributed, which gives the way to recover after an aborted transfer.

Top module: `disp_ram_writer`

## Requirements
- R1: After reset the block is idle (`busy_o`, `we_o`, `ovf_o` low, `wmask_o` zero), the pointer is 0 and the subaddress counter is 0.
- R2: With `mode_i`=0 (static), an accepted byte produces 8 word writes. Each has mask 4'b0001, and word k carries byte bit 7-k in row 0.
- R3: With `mode_i`=1 (1:2), an accepted byte produces 4 word writes with mask 4'b0011. Word k carries bit 7-2k in row 0 and bit 6-2k in row 1.
- R4: With `mode_i`=2 (1:3), an accepted byte produces 3 word writes. The masks are 4'b0111, 4'b0111 and 4'b0011. Row r of word k carries bit 7-(3k+r), and row 3 is never written.
- R5: With `mode_i`=3 (1:4), an accepted byte produces 2 word writes with mask 4'b1111. Row r of word k carries bit 7-(4k+r).
- R6: A byte is accepted when `byte_valid_i` is high and `busy_o` is low. From the next cycle, `busy_o` stays high for exactly one cycle per word. `waddr_o` starts at the pointer and steps by one each cycle. `byte_valid_i` is ignored while busy.
- R7: `load_ptr_i` with `ptr_val_i` below DEPTH sets the pointer in the next cycle. It takes priority over a byte on `byte_valid_i` in the same cycle, and it ends any byte in progress, so `busy_o` is low in the next cycle. A load with a value of DEPTH or more is ignored.
- R8: While the subaddress counter differs from `hw_addr_i`, `we_o` stays low, but the pointer still steps once per word.
- R9: `dev_sel_i` loads `dev_val_i` into the subaddress counter in the next cycle. It wins over a wrap increment at the same edge.
- R10: A step from address DEPTH-1 wraps the pointer to 0 and increments the subaddress counter modulo 8. `ovf_o` is high for exactly the one cycle after that step.
- R11: The mode is captured when a byte is accepted. Changes on `mode_i` while busy do not affect that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| byte_valid_i | input | 1 | Data byte offered |
| byte_i | input | 8 | Data byte |
| load_ptr_i | input | 1 | Pointer load strobe |
| ptr_val_i | input | AW (6) | New pointer value |
| dev_sel_i | input | 1 | Subaddress load strobe |
| dev_val_i | input | SUBW (3) | New subaddress counter value |
| mode_i | input | 2 | Drive mode: 0 static, 1 1:2, 2 1:3, 3 1:4 |
| hw_addr_i | input | SUBW (3) | Strapped device subaddress |
| we_o | output | 1 | Word write enable |
| waddr_o | output | AW (6) | Word address |
| wdata_o | output | 4 | Word data, bit r = row r |
| wmask_o | output | 4 | Per-row write mask |
| busy_o | output | 1 | Byte distribution in progress |
| ovf_o | output | 1 | Pointer wrapped on the previous step |

## Verification
The first word of an accepted byte appears in the cycle right after the accepting edge. Each later word follows one cycle after the one before it. `ovf_o` and the incremented subaddress appear one cycle after the word written at the last address. Pointer and subaddress loads take effect in the cycle after their strobe. The bench drives inputs just after the falling edge and compares every output a moment later against a behavioural model. That model advances exactly once per rising edge, so each result is checked in the cycle it is due.

// File: rtl/disp_wr_pkg.sv
`timescale 1ns/1ps
package disp_wr_pkg;
  localparam int unsigned DW_ROWS = 4;
  localparam int unsigned DW_BYTE = 8;

  typedef enum logic [1:0] {
    MODE_STATIC = 2'd0,
    MODE_MUX2   = 2'd1,
    MODE_MUX3   = 2'd2,
    MODE_MUX4   = 2'd3
  } drive_mode_e;

  function automatic logic [2:0] rows_per_word(drive_mode_e m);
    return {1'b0, m} + 3'd1;
  endfunction

  // ceil(8 / rows)
  function automatic logic [3:0] words_per_byte(drive_mode_e m);
    case (m)
      MODE_STATIC: return 4'd8;
      MODE_MUX2:   return 4'd4;
      MODE_MUX3:   return 4'd3;
      default:     return 4'd2;
    endcase
  endfunction
endpackage

// File: rtl/dw_ptr.sv
`timescale 1ns/1ps
module dw_ptr #(
  parameter int unsigned DEPTH = 60,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [AW-1:0] load_val_i,
  input  logic          step_i,
  output logic [AW-1:0] ptr_o,
  output logic          wrap_o
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q;

  assign wrap_o = step_i && (ptr_q == LAST);
  assign ptr_o  = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (load_i) begin
      ptr_q <= load_val_i;
    end else if (step_i) begin
      ptr_q <= wrap_o ? '0 : ptr_q + 1'b1;
    end
  end
endmodule

// File: rtl/dw_sub.sv
`timescale 1ns/1ps
module dw_sub #(
  parameter int unsigned SUBW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            load_i,
  input  logic [SUBW-1:0] load_val_i,
  input  logic            inc_i,
  output logic [SUBW-1:0] sub_o
);
  logic [SUBW-1:0] sub_q;

  assign sub_o = sub_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sub_q <= '0;
    end else if (load_i) begin
      sub_q <= load_val_i;
    end else if (inc_i) begin
      sub_q <= sub_q + 1'b1;
    end
  end
endmodule

// File: rtl/dw_spread.sv
`timescale 1ns/1ps
module dw_spread
  import disp_wr_pkg::*;
#(
  parameter int unsigned NROWS  = DW_ROWS,
  parameter int unsigned BYTE_W = DW_BYTE,
  parameter int unsigned IW     = $clog2(BYTE_W)
) (
  input  logic              active_i,
  input  logic [BYTE_W-1:0] byte_i,
  input  drive_mode_e       mode_i,
  input  logic [IW-1:0]     idx_i,
  output logic [NROWS-1:0]  data_o,
  output logic [NROWS-1:0]  mask_o
);
  localparam int unsigned SW = IW + $clog2(NROWS) + 1;
  localparam logic [IW-1:0] TOP_BIT = IW'(BYTE_W - 1);

  logic [SW-1:0] rows;
  assign rows = SW'(rows_per_word(mode_i));

  for (genvar r = 0; r < NROWS; r++) begin : g_row
    logic [SW-1:0] slot;
    logic          hit;
    // slot = position in the byte, counted from the MSB
    assign slot      = SW'(idx_i) * rows + SW'(r);
    assign hit       = active_i && (SW'(r) < rows) && (slot < SW'(BYTE_W));
    assign mask_o[r] = hit;
    assign data_o[r] = hit && byte_i[TOP_BIT - slot[IW-1:0]];
  end
endmodule

// File: rtl/disp_ram_writer.sv
`timescale 1ns/1ps
module disp_ram_writer
  import disp_wr_pkg::*;
#(
  parameter  int unsigned DEPTH = 60,
  parameter  int unsigned SUBW  = 3,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               byte_valid_i,
  input  logic [DW_BYTE-1:0] byte_i,
  input  logic               load_ptr_i,
  input  logic [AW-1:0]      ptr_val_i,
  input  logic               dev_sel_i,
  input  logic [SUBW-1:0]    dev_val_i,
  input  logic [1:0]         mode_i,
  input  logic [SUBW-1:0]    hw_addr_i,
  output logic               we_o,
  output logic [AW-1:0]      waddr_o,
  output logic [DW_ROWS-1:0] wdata_o,
  output logic [DW_ROWS-1:0] wmask_o,
  output logic               busy_o,
  output logic               ovf_o
);
  localparam int unsigned IW = $clog2(DW_BYTE);
  localparam logic [AW:0] DEPTH_W = (AW + 1)'(DEPTH);

  logic               busy_q, ovf_q;
  logic [IW-1:0]      idx_q;
  logic [DW_BYTE-1:0] byte_q;
  drive_mode_e        mode_q;
  logic [SUBW-1:0]    sub_q;
  logic               load_ok, step, accept, last_word, wrap;

  assign load_ok   = load_ptr_i && ({1'b0, ptr_val_i} < DEPTH_W);
  assign step      = busy_q && !load_ok;
  assign accept    = !busy_q && !load_ok && byte_valid_i;
  assign last_word = ({1'b0, idx_q} + 4'd1) == words_per_byte(mode_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      idx_q  <= '0;
      byte_q <= '0;
      mode_q <= MODE_STATIC;
      ovf_q  <= 1'b0;
    end else begin
      ovf_q <= wrap;
      if (load_ok) begin
        busy_q <= 1'b0;
      end else if (step) begin
        idx_q <= idx_q + 1'b1;
        if (last_word) busy_q <= 1'b0;
      end else if (accept) begin
        busy_q <= 1'b1;
        idx_q  <= '0;
        byte_q <= byte_i;
        mode_q <= drive_mode_e'(mode_i);
      end
    end
  end

  dw_ptr #(.DEPTH(DEPTH), .AW(AW)) u_ptr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load_ok),
    .load_val_i (ptr_val_i),
    .step_i     (step),
    .ptr_o      (waddr_o),
    .wrap_o     (wrap)
  );

  dw_sub #(.SUBW(SUBW)) u_sub (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (dev_sel_i),
    .load_val_i (dev_val_i),
    .inc_i      (wrap),
    .sub_o      (sub_q)
  );

  dw_spread #(.NROWS(DW_ROWS), .BYTE_W(DW_BYTE), .IW(IW)) u_spread (
    .active_i (busy_q),
    .byte_i   (byte_q),
    .mode_i   (mode_q),
    .idx_i    (idx_q),
    .data_o   (wdata_o),
    .mask_o   (wmask_o)
  );

  assign we_o   = busy_q && (sub_q == hw_addr_i);
  assign busy_o = busy_q;
  assign ovf_o  = ovf_q;
endmodule

// File: rtl/disp_ram_writer_chk.sv
`timescale 1ns/1ps
module disp_ram_writer_chk #(
  parameter int unsigned DEPTH = 60,
  parameter int unsigned SUBW  = 3,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            load_ptr_i,
  input logic [AW-1:0]   ptr_val_i,
  input logic            dev_sel_i,
  input logic [SUBW-1:0] dev_val_i,
  input logic [SUBW-1:0] hw_addr_i,
  input logic            we_o,
  input logic [AW-1:0]   waddr_o,
  input logic [3:0]      wmask_o,
  input logic            busy_o,
  input logic            ovf_o,
  input logic [SUBW-1:0] sub_q
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [AW:0]   LIM  = (AW + 1)'(DEPTH);

  logic ld_ok;
  assign ld_ok = load_ptr_i && ({1'b0, ptr_val_i} < LIM);

  // R6
  we_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_o |-> busy_o);

  // R6
  mask_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (wmask_o == 4'b0000));

  // R6
  addr_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o && !ld_ok)) |->
      (waddr_o == (($past(waddr_o) == LAST) ? '0 : $past(waddr_o) + 1'b1)));

  // R8
  no_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (sub_q != hw_addr_i)) |-> !we_o);

  // R7
  ptr_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ld_ok |=> (!busy_o && (waddr_o == $past(ptr_val_i))));

  // R9
  dev_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dev_sel_i |=> (sub_q == $past(dev_val_i)));

  // R10
  ovf_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ovf_o |-> $past(busy_o && !ld_ok && (waddr_o == LAST)));

  // R10
  ovf_sub_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ovf_o && !$past(dev_sel_i)) |-> (sub_q == $past(sub_q) + 1'b1));
endmodule

bind disp_ram_writer disp_ram_writer_chk #(.DEPTH(DEPTH), .SUBW(SUBW), .AW(AW)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .load_ptr_i (load_ptr_i),
  .ptr_val_i  (ptr_val_i),
  .dev_sel_i  (dev_sel_i),
  .dev_val_i  (dev_val_i),
  .hw_addr_i  (hw_addr_i),
  .we_o       (we_o),
  .waddr_o    (waddr_o),
  .wmask_o    (wmask_o),
  .busy_o     (busy_o),
  .ovf_o      (ovf_o),
  .sub_q      (sub_q)
);

// File: tb/sim_disp_ram_writer.sv
`timescale 1ns/1ps
module sim_disp_ram_writer;
  localparam int DEPTH = 60;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       byte_valid, load_ptr, dev_sel;
  logic [7:0] byte_in;
  logic [5:0] ptr_val;
  logic [2:0] dev_val, hw;
  logic [1:0] mode;
  logic       we, busy, ovf;
  logic [5:0] waddr;
  logic [3:0] wdata, wmask;

  always #10 clk = ~clk;

  disp_ram_writer u0 (
    .clk_i(clk), .rst_ni(rst_n), .byte_valid_i(byte_valid), .byte_i(byte_in),
    .load_ptr_i(load_ptr), .ptr_val_i(ptr_val), .dev_sel_i(dev_sel), .dev_val_i(dev_val),
    .mode_i(mode), .hw_addr_i(hw), .we_o(we), .waddr_o(waddr), .wdata_o(wdata),
    .wmask_o(wmask), .busy_o(busy), .ovf_o(ovf)
  );

  int total = 0, bad = 0;
  string cur = "R1";

  // reference model state
  int mptr = 0, msub = 0, mk = 0, mrows = 1, mwords = 8;
  bit mbusy = 0, movf = 0;
  logic [7:0] mbyte = 8'h00;

  task automatic chk(string what, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s %s got %0h exp %0h", cur, what, got, exp);
    end
  endtask

  task automatic compare();
    logic [3:0] ed, em;
    int slot;
    ed = 4'b0; em = 4'b0;
    if (mbusy)
      for (int r = 0; r < 4; r++) begin
        slot = mk * mrows + r;
        if (r < mrows && slot < 8) begin
          em[r] = 1'b1;
          ed[r] = mbyte[7 - slot];
        end
      end
    chk("busy", 32'(busy), 32'(mbusy));
    chk("we", 32'(we), 32'(mbusy && (msub == int'(hw))));
    chk("mask", 32'(wmask), 32'(em));
    chk("data", 32'(wdata), 32'(ed));
    chk("ovf", 32'(ovf), 32'(movf));
    chk("addr", 32'(waddr), 32'(mptr));
  endtask

  task automatic model_edge();
    bit ld, wrap;
    ld = rst_n && load_ptr && (int'(ptr_val) < DEPTH);
    wrap = 0;
    if (!rst_n) return;
    if (ld) begin
      mptr = int'(ptr_val);
      mbusy = 0;
    end else if (mbusy) begin
      wrap = (mptr == DEPTH - 1);
      mptr = wrap ? 0 : mptr + 1;
      mk++;
      if (mk == mwords) mbusy = 0;
    end else if (byte_valid) begin
      mbusy = 1;
      mk = 0;
      mbyte = byte_in;
      mrows = int'(mode) + 1;
      mwords = (8 + mrows - 1) / mrows;
    end
    movf = wrap;
    if (dev_sel) msub = int'(dev_val);
    else if (wrap) msub = (msub + 1) % 8;
  endtask

  task automatic cycle();
    #1 compare();
    @(posedge clk);
    model_edge();
    @(negedge clk);
  endtask

  task automatic drain();
    while (mbusy) cycle();
    cycle();
  endtask

  task automatic send(logic [7:0] b, logic [1:0] m);
    byte_valid = 1'b1; byte_in = b; mode = m;
    cycle();
    byte_valid = 1'b0;
    drain();
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL R6 watchdog got running exp finished");
    summary();
    $finish;
  end

  initial begin
    rst_n = 1'b0; byte_valid = 0; load_ptr = 0; dev_sel = 0;
    byte_in = 0; ptr_val = 0; dev_val = 0; hw = 0; mode = 0;
    // R1: idle during and right after reset
    @(negedge clk);
    cycle(); cycle();
    rst_n = 1'b1;
    cycle();

    cur = "R2"; send(8'hA5, 2'd0);
    cur = "R3"; send(8'h3C, 2'd1);
    cur = "R4"; send(8'hB7, 2'd2);
    cur = "R5"; send(8'h6E, 2'd3);

    // R11: mode_i changes while busy
    cur = "R11";
    byte_valid = 1; byte_in = 8'h59; mode = 2'd2;
    cycle();
    byte_valid = 0; mode = 2'd3; byte_in = 8'hFF;
    drain();
    mode = 2'd0;

    // R6: valid held high across busy periods
    cur = "R6";
    byte_valid = 1; byte_in = 8'h96; mode = 2'd3;
    repeat (10) cycle();
    byte_in = 8'h4B; mode = 2'd1;
    repeat (5) cycle();
    byte_valid = 0;
    drain();

    // R7: load, cancel mid-byte, out-of-range load ignored
    cur = "R7";
    load_ptr = 1; ptr_val = 6'd30; byte_valid = 1; byte_in = 8'h12;
    cycle();
    load_ptr = 0; byte_valid = 0;
    cycle();
    byte_valid = 1; byte_in = 8'hF0; mode = 2'd0;
    cycle();
    byte_valid = 0;
    repeat (3) cycle();
    load_ptr = 1; ptr_val = 6'd40;
    cycle();
    load_ptr = 0;
    cycle();
    load_ptr = 1; ptr_val = 6'd60;
    cycle();
    ptr_val = 6'd63;
    cycle();
    load_ptr = 0;
    send(8'h0F, 2'd3);

    // R10: wrap from 59, subaddress moves on, later words blocked (R8)
    cur = "R10";
    load_ptr = 1; ptr_val = 6'd57;
    cycle();
    load_ptr = 0;
    send(8'hC3, 2'd0);

    // R9: subaddress load, then matching writes
    cur = "R9";
    hw = 3'd1;
    send(8'h81, 2'd3);
    dev_sel = 1; dev_val = 3'd5;
    cycle();
    dev_sel = 0;
    hw = 3'd5;
    send(8'h42, 2'd1);

    // R8: mismatch keeps we low but pointer advances
    cur = "R8";
    hw = 3'd2;
    send(8'hFF, 2'd3);
    send(8'hAA, 2'd2);
    hw = 3'd5;
    send(8'h11, 2'd0);

    // R10: wrap inside a 1:3 byte, dev select at the wrap edge wins (R9)
    cur = "R10";
    load_ptr = 1; ptr_val = 6'd58;
    cycle();
    load_ptr = 0;
    send(8'hE7, 2'd2);
    load_ptr = 1; ptr_val = 6'd59;
    cycle();
    load_ptr = 0;
    byte_valid = 1; byte_in = 8'h5A; mode = 2'd3;
    cycle();
    byte_valid = 0;
    dev_sel = 1; dev_val = 3'd5;
    cycle();
    dev_sel = 0;
    drain();
    send(8'h3E, 2'd3);

    summary();
    $finish;
  end
endmodule